// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept, based on its six-byte destination address. The address enters as a byte stream: a start strobe marks the first byte, and the next five valid bytes complete the address. One clock after the sixth byte is taken, the block raises a single-cycle result strobe together with an accept flag. Bytes after the sixth, and idle cycles between bytes, do not affect the result.

The rules come from configuration inputs that software would normally hold in registers. These are the station address (split across a 32-bit and a 16-bit word), a 64-bit multicast hash table held in two 32-bit words, and three mode bits: promiscuous, broadcast reject, and unicast hashing. The hash index is formed from a CRC-32 computed on the fly over the six address bytes. The rest of frame reception is not handled here.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `res_valid` and `res_accept` are 0. `res_accept` is never 1 while `res_valid` is 0.
- R2: A byte is taken on a clock edge where `in_valid` is 1. A taken byte with `in_sof` = 1 is address byte 0, and the next five taken bytes without `in_sof` are bytes 1 to 5. `res_valid` is 1 for exactly one cycle, namely the cycle after the edge that takes byte 5.
- R3: The frame is accepted when its address equals the station address. Byte 0 is `stn_hi_word[15:8]`, byte 1 is `stn_hi_word[7:0]`, and bytes 2 to 5 are `stn_lo_word[31:24]` down to `stn_lo_word[7:0]`.
- R4: A multicast address (bit 0 of byte 0 set, and not all ones) is accepted when its hash bit is set. The CRC uses the reflected polynomial 0xEDB88320, starts at all ones, takes each byte least significant bit first in order from byte 0 to byte 5, and is not inverted at the end. The index is CRC bits 31:26. Index bit 5 = 1 selects `hash_hi_word` and 0 selects `hash_lo_word`; index bits 4:0 pick the bit within that word.
- R5: With both hash words all ones, every multicast address that is not broadcast is accepted.
- R6: The all-ones address is judged only by the broadcast rule and never by the hash table. It is rejected when `cfg_bcast_reject` is 1 and accepted when it is 0, unless R3 or R8 accepts it.
- R7: With `cfg_uc_hash` = 1, a unicast address that does not match the station address is accepted when its hash bit (same index as R4) is set.
- R8: With `cfg_promisc` = 1, every address is accepted.
- R9: A taken byte with `in_sof` = 1 restarts the address even when another address is partly received. Bytes after byte 5 and cycles with `in_valid` = 0 produce no result and do not change the address.
- R10: With `cfg_uc_hash` = 0, a unicast address that does not match the station address is rejected, even when its hash bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | Marks the first address byte |
| in_data | input | 8 | Address byte |
| stn_lo_word | input | 32 | Station address bytes 2 to 5 |
| stn_hi_word | input | 16 | Station address bytes 0 and 1 |
| hash_lo_word | input | 32 | Hash bits for indices 0 to 31 |
| hash_hi_word | input | 32 | Hash bits for indices 32 to 63 |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_reject | input | 1 | Reject the all-ones address |
| cfg_uc_hash | input | 1 | Apply the hash table to unicast addresses |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Verdict, meaningful while res_valid is 1 |

## Verification
The hardest case to reach is a hit in one particular hash bit. That bit is fixed by a CRC over the address, so it cannot be selected directly from the ports. The bench computes the CRC of each generated address on its own and loads a table with only that one bit set, then loads the complement table. This is swept over many multicast and unicast addresses, so every index region and both hash words are exercised. Restart in the middle of an address, gaps between bytes and trailing bytes are driven separately, and each one is checked for exactly one result strobe.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int ADDR_BYTES  = 6;
    localparam int OCTET_W     = 8;
    localparam int CNT_W       = $clog2(ADDR_BYTES + 1);
    localparam int CRC_W       = 32;
    localparam int HASH_WORD_W = 32;
    localparam int HASH_SEL_W  = $clog2(HASH_WORD_W);
    localparam int HASH_IDX_W  = HASH_SEL_W + 1;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = {CRC_W{1'b1}};

    typedef logic [OCTET_W-1:0]                   octet_t;
    typedef logic [ADDR_BYTES-1:0][OCTET_W-1:0]   mac_t;
    typedef logic [CRC_W-1:0]                     crc_t;
    typedef logic [HASH_IDX_W-1:0]                hidx_t;

    typedef enum logic [1:0] {
        CLS_UNICAST   = 2'd0,
        CLS_MULTICAST = 2'd1,
        CLS_BROADCAST = 2'd2
    } addr_class_e;

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

    // One byte of the reflected CRC, LSB of the byte first.
    function automatic crc_t crc_step_byte(input crc_t c, input octet_t d);
        crc_t r;
        r = c ^ {{(CRC_W-OCTET_W){1'b0}}, d};
        for (int i = 0; i < OCTET_W; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic addr_class_e classify(input mac_t a);
        if (a == {(ADDR_BYTES*OCTET_W){1'b1}}) return CLS_BROADCAST;
        else if (a[0][0])                     return CLS_MULTICAST;
        else                                  return CLS_UNICAST;
    endfunction

endpackage

// File: rtl/daf_capture.sv
module daf_capture
    import daf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_sof,
    input  octet_t in_data,
    output mac_t   addr_full,
    output logic   take_first,
    output logic   take_more,
    output logic   done
);
    localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] cnt;
    mac_t             held;

    assign take_first = in_valid && in_sof;
    assign take_more  = in_valid && !in_sof && (cnt < CNT_IDLE);
    assign done       = take_more && (cnt == CNT_LAST);

    // Address as it stands including the byte taken this cycle.
    always_comb begin
        addr_full = held;
        if (take_first) begin
            addr_full[0] = in_data;
        end
        for (int k = 1; k < ADDR_BYTES; k++) begin
            if (take_more && cnt == CNT_W'(k)) addr_full[k] = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CNT_IDLE;
            held <= '0;
        end else begin
            held <= addr_full;
            if (take_first)     cnt <= CNT_W'(1);
            else if (take_more) cnt <= cnt + CNT_W'(1);
        end
    end

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !$isunknown(done)) |=> (cnt == CNT_IDLE));

    assert_count_range_R9: assert property (@(posedge clk) disable iff (rst)
        take_first |=> (cnt == CNT_W'(1)));

endmodule

// File: rtl/daf_crc.sv
module daf_crc
    import daf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take_first,
    input  logic   take_more,
    input  octet_t in_data,
    output hidx_t  hash_idx
);
    crc_t crc_q;
    crc_t crc_next;

    always_comb begin
        crc_next = crc_step_byte(take_first ? CRC_SEED : crc_q, in_data);
    end

    assign hash_idx = crc_next[CRC_W-1 -: HASH_IDX_W];

    always_ff @(posedge clk) begin
        if (rst)                          crc_q <= CRC_SEED;
        else if (take_first || take_more) crc_q <= crc_next;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(take_first || take_more) |=> $stable(crc_q));

endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   done,
    input  mac_t                   addr_full,
    input  hidx_t                  hash_idx,
    input  logic [31:0]            stn_lo_word,
    input  logic [15:0]            stn_hi_word,
    input  logic [HASH_WORD_W-1:0] hash_lo_word,
    input  logic [HASH_WORD_W-1:0] hash_hi_word,
    input  logic                   cfg_promisc,
    input  logic                   cfg_bcast_reject,
    input  logic                   cfg_uc_hash,
    output verdict_t               verdict
);
    mac_t        station;
    addr_class_e cls;
    logic        hash_hit;
    logic        stn_match;
    logic        accept_now;

    assign station[0] = stn_hi_word[15:8];
    assign station[1] = stn_hi_word[7:0];
    for (genvar k = 2; k < ADDR_BYTES; k++) begin : g_stn
        assign station[k] = stn_lo_word[OCTET_W*(ADDR_BYTES-1-k) +: OCTET_W];
    end

    always_comb begin
        cls       = classify(addr_full);
        stn_match = (addr_full == station);
        hash_hit  = hash_idx[HASH_IDX_W-1] ? hash_hi_word[hash_idx[HASH_SEL_W-1:0]]
                                           : hash_lo_word[hash_idx[HASH_SEL_W-1:0]];
        accept_now = cfg_promisc || stn_match;
        unique case (cls)
            CLS_BROADCAST: if (!cfg_bcast_reject)     accept_now = 1'b1;
            CLS_MULTICAST: if (hash_hit)              accept_now = 1'b1;
            CLS_UNICAST:   if (cfg_uc_hash && hash_hit) accept_now = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.valid  <= done;
            verdict.accept <= done && accept_now;
        end
    end

    assert_promisc_R8: assert property (@(posedge clk) disable iff (rst)
        (verdict.valid && $past(cfg_promisc)) |-> verdict.accept);

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [7:0]  in_data,
    input  logic [31:0] stn_lo_word,
    input  logic [15:0] stn_hi_word,
    input  logic [31:0] hash_lo_word,
    input  logic [31:0] hash_hi_word,
    input  logic        cfg_promisc,
    input  logic        cfg_bcast_reject,
    input  logic        cfg_uc_hash,
    output logic        res_valid,
    output logic        res_accept
);
    mac_t     addr_full;
    logic     take_first;
    logic     take_more;
    logic     done;
    hidx_t    hash_idx;
    verdict_t verdict;

    daf_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_data    (in_data),
        .addr_full  (addr_full),
        .take_first (take_first),
        .take_more  (take_more),
        .done       (done)
    );

    daf_crc u_crc (
        .clk        (clk),
        .rst        (rst),
        .take_first (take_first),
        .take_more  (take_more),
        .in_data    (in_data),
        .hash_idx   (hash_idx)
    );

    daf_decide u_decide (
        .clk              (clk),
        .rst              (rst),
        .done             (done),
        .addr_full        (addr_full),
        .hash_idx         (hash_idx),
        .stn_lo_word      (stn_lo_word),
        .stn_hi_word      (stn_hi_word),
        .hash_lo_word     (hash_lo_word),
        .hash_hi_word     (hash_hi_word),
        .cfg_promisc      (cfg_promisc),
        .cfg_bcast_reject (cfg_bcast_reject),
        .cfg_uc_hash      (cfg_uc_hash),
        .verdict          (verdict)
    );

    assign res_valid  = verdict.valid;
    assign res_accept = verdict.accept;

    assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_follows_last_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(done));

    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_accept);

endmodule

// File: tb/test_dest_addr_filter.sv
module test_dest_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [31:0] stn_lo_word = 32'h0;
    logic [15:0] stn_hi_word = 16'h0;
    logic [31:0] hash_lo_word = 32'h0;
    logic [31:0] hash_hi_word = 32'h0;
    logic        cfg_promisc = 1'b0;
    logic        cfg_bcast_reject = 1'b0;
    logic        cfg_uc_hash = 1'b0;
    logic        res_valid;
    logic        res_accept;

    int total = 0;
    int bad = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    dest_addr_filter i_dest_addr_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .stn_lo_word(stn_lo_word), .stn_hi_word(stn_hi_word),
        .hash_lo_word(hash_lo_word), .hash_hi_word(hash_hi_word),
        .cfg_promisc(cfg_promisc), .cfg_bcast_reject(cfg_bcast_reject),
        .cfg_uc_hash(cfg_uc_hash), .res_valid(res_valid), .res_accept(res_accept)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bit-serial CRC over byte 0..5 (address bits 47:40 are byte 0).
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ a[47 - 8*k - 7 + b];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic [63:0] one_hot64(input logic [5:0] i);
        return 64'd1 << i;
    endfunction

    task automatic load_hash(input logic [63:0] h);
        hash_hi_word = h[63:32];
        hash_lo_word = h[31:0];
    endtask

    function automatic logic [47:0] next_addr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return {lfsr[15:0] ^ lfsr[31:16], lfsr};
    endfunction

    // Sends an address, idle gap after each non-final byte; checks the strobe.
    task automatic send_addr(input logic [47:0] a, input int gap, input string tag, output logic acc);
        logic v2;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (k == 0); in_data = a[47 - 8*k -: 8];
            if (k < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h5A;
                    check(res_valid == 1'b0, {tag, " R2 no strobe in gap"}, res_valid, 0);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        check(res_valid == 1'b1, {tag, " R2 strobe after byte 5"}, res_valid, 1);
        acc = res_accept;
        @(negedge clk);
        v2 = res_valid;
        check(v2 == 1'b0, {tag, " R2 strobe one cycle"}, v2, 0);
    endtask

    task automatic expect_verdict(input logic [47:0] a, input logic exp, input string tag);
        logic acc;
        send_addr(a, 0, tag, acc);
        check(acc == exp, tag, acc, exp);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        logic        acc;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(res_valid == 0 && res_accept == 0, "R1 during reset", {res_valid, res_accept}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(res_valid == 0 && res_accept == 0, "R1 after reset", {res_valid, res_accept}, 0);

        // R3 station match and single-byte mismatches
        stn_hi_word = 16'h0211; stn_lo_word = 32'h2233_4455;
        expect_verdict(48'h0211_2233_4455, 1'b1, "R3 station match");
        for (int k = 0; k < 6; k++) begin
            a = 48'h0211_2233_4455 ^ (48'h04 << (8*(5-k)));
            expect_verdict(a, 1'b0, "R3 one byte differs");
        end

        // R10 unicast with full hash table but hashing off
        load_hash('1);
        expect_verdict(48'h0A00_0000_0001, 1'b0, "R10 unicast hash off");

        // R4 single-bit hash sweep on multicast addresses
        for (int n = 0; n < 64; n++) begin
            a = next_addr();
            a[40] = 1'b1;
            if (a == '1) a[0] = 1'b0;
            ix = ref_index(a);
            load_hash(one_hot64(ix));
            expect_verdict(a, 1'b1, "R4 hash bit set");
            load_hash(~one_hot64(ix));
            expect_verdict(a, 1'b0, "R4 hash bit clear");
        end

        // R5 all ones table
        load_hash('1);
        for (int n = 0; n < 16; n++) begin
            a = next_addr(); a[40] = 1'b1; a[1] = 1'b0;
            expect_verdict(a, 1'b1, "R5 all-ones table");
        end

        // R6 broadcast
        cfg_bcast_reject = 1'b1;
        expect_verdict('1, 1'b0, "R6 broadcast rejected despite full table");
        load_hash('0);
        cfg_bcast_reject = 1'b0;
        expect_verdict('1, 1'b1, "R6 broadcast allowed with empty table");

        // R7 unicast hashing
        cfg_uc_hash = 1'b1;
        for (int n = 0; n < 32; n++) begin
            a = next_addr(); a[40] = 1'b0;
            ix = ref_index(a);
            load_hash(one_hot64(ix));
            expect_verdict(a, 1'b1, "R7 unicast hash hit");
            load_hash(~one_hot64(ix));
            expect_verdict(a, 1'b0, "R7 unicast hash miss");
        end
        cfg_uc_hash = 1'b0;
        load_hash('0);

        // R8 promiscuous
        cfg_promisc = 1'b1; cfg_bcast_reject = 1'b1;
        expect_verdict(48'h0C00_1234_5678, 1'b1, "R8 promisc unicast");
        expect_verdict('1, 1'b1, "R8 promisc broadcast");
        expect_verdict(48'h0100_5E00_0001, 1'b1, "R8 promisc multicast");
        cfg_promisc = 1'b0;

        // R9 gaps between bytes
        send_addr(48'h0211_2233_4455, 2, "R9 gaps", acc);
        check(acc == 1'b1, "R9 gaps keep address", acc, 1);

        // R9 restart mid-address, then trailing bytes
        @(negedge clk); in_valid = 1; in_sof = 1; in_data = 8'hFF;
        @(negedge clk); in_sof = 0; in_data = 8'hEE;
        @(negedge clk); in_data = 8'hDD;
        @(negedge clk); in_valid = 0;
        check(res_valid == 0, "R9 no strobe for partial address", res_valid, 0);
        send_addr(48'h0211_2233_4455, 0, "R9 restart", acc);
        check(acc == 1'b1, "R9 restart uses new address", acc, 1);
        for (int t = 0; t < 8; t++) begin
            @(negedge clk); in_valid = 1; in_sof = 0; in_data = 8'(t);
            check(res_valid == 0, "R9 trailing bytes ignored", res_valid, 0);
        end
        @(negedge clk); in_valid = 0;
        check(res_valid == 0, "R9 trailing bytes ignored", res_valid, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule